// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits between the request queue of an external bus controller and the sequencer that runs external bus cycles. Each new access is held back by a number of idle cycles before it may start. The block remembers the direction and chip-select space of the last access that started. It sorts the pair formed by that access and the waiting one into a class, and reads a 2-bit idle count for that class from the configuration word of the previous access's space. It then raises the result to the minimum that the internal-bus hand-off needs. The extra cycles keep a slow device's output buffers from still driving when the next device drives the bus.

The queue keeps a request stable on `req_valid_i`, `req_write_i` and `req_space_i` until `start_o` pulses. While the block holds the request back, `idle_o` is high. A request may appear in the cycle right after a start, so accesses can follow each other back to back. If the bus sees no request for three cycles in a row, the block forgets the previous access.

Top module: `idle_gap_inserter`

## Requirements
- R1: When no previous access is remembered, a read request starts in the cycle it is first presented: `start_o` is high in that cycle and `idle_o` never rises.
- R2: When no previous access is remembered, a write request is preceded by exactly one idle cycle.
- R3: After a write, the next access (read or write) waits exactly the count in bits [1:0] of the previous space's 10-bit configuration word.
- R4: After a read, a read waits the larger of 1 and the programmed count. The count is bits [9:8] of the word when both spaces are equal and bits [7:6] when they differ.
- R5: After a read, a write waits the larger of 2 and the programmed count. The count is bits [5:4] of the word when both spaces are equal and bits [3:2] when they differ.
- R6: "Same space" means `req_space_i` equals the space index of the previous started access.
- R7: The configuration word used is the one of the previous access's space, found at `cfg_idle_i[10*s +: 10]` for space s, whatever space the new request targets.
- R8: After three or more consecutive cycles with `req_valid_i` low and no request pending, the previous access is forgotten and R1/R2 apply. After two such cycles it is still remembered.
- R9: `idle_o` is high only while a request is presented. It is high for exactly the computed count of consecutive cycles, directly followed by one cycle with `start_o` high, and it is never high together with `start_o`.
- R10: After reset no previous access is remembered, and with no request both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | A request is waiting; held until `start_o` |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| req_space_i | input | SPACE_W | Chip-select space of the request |
| cfg_idle_i | input | 10*NUM_SPACES | Per-space idle counts, 10 bits per space |
| start_o | output | 1 | The external cycle for the presented request starts now |
| idle_o | output | 1 | An inserted idle cycle is in progress |

## Verification
The bench builds the block with four spaces, so a 2-bit space index reaches every space. Each space is given its own mix of the five class counts, so every class meets each of the values 0 to 3 in at least one space. That makes the selection of the previous space's word, and its same/different split, visible in the measured gaps. Directed sequences reach the mandatory floors: read-to-read with a programmed 0, and read-to-write with 0 and 1. They also reach the forgetting threshold with gaps of two and three empty cycles. A long run driven by a shift-register sequence then mixes directions, spaces and gaps of 0 to 4 cycles.

// File: rtl/idlegap_pkg.sv
package idlegap_pkg;

    localparam int CNT_W    = 2;
    localparam int CFG_W    = 10;
    localparam int IDLE_MAX = 3;

    typedef logic [CNT_W-1:0] idle_cnt_t;
    typedef logic [CFG_W-1:0] space_cfg_t;

    typedef enum logic [2:0] {
        PC_NONE,
        PC_AFTER_WR,
        PC_RW_OTHER,
        PC_RW_SAME,
        PC_RR_OTHER,
        PC_RR_SAME
    } pair_class_e;

    typedef struct packed {
        logic valid;
        logic write;
    } prev_kind_t;

    function automatic pair_class_e classify(input logic prev_ok,
                                             input logic prev_wr,
                                             input logic new_wr,
                                             input logic same);
        pair_class_e c;
        if (!prev_ok)      c = PC_NONE;
        else if (prev_wr)  c = PC_AFTER_WR;
        else if (new_wr)   c = same ? PC_RW_SAME : PC_RW_OTHER;
        else               c = same ? PC_RR_SAME : PC_RR_OTHER;
        return c;
    endfunction

    function automatic int field_lsb(input pair_class_e c);
        int lsb;
        case (c)
            PC_RW_OTHER: lsb = 2;
            PC_RW_SAME:  lsb = 4;
            PC_RR_OTHER: lsb = 6;
            PC_RR_SAME:  lsb = 8;
            default:     lsb = 0;
        endcase
        return lsb;
    endfunction

    function automatic idle_cnt_t mandatory_floor(input logic prev_ok,
                                                  input logic prev_wr,
                                                  input logic new_wr);
        idle_cnt_t f;
        if (!prev_ok)     f = new_wr ? idle_cnt_t'(1) : idle_cnt_t'(0);
        else if (prev_wr) f = idle_cnt_t'(0);
        else              f = new_wr ? idle_cnt_t'(2) : idle_cnt_t'(1);
        return f;
    endfunction

    function automatic idle_cnt_t cnt_max(input idle_cnt_t a, input idle_cnt_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/idlegap_prev_tracker.sv
module idlegap_prev_tracker
    import idlegap_pkg::*;
#(
    parameter int SPACE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               quiet_i,
    input  logic               new_wr_i,
    input  logic [SPACE_W-1:0] new_space_i,
    output logic               prev_ok_o,
    output logic               prev_wr_o,
    output logic [SPACE_W-1:0] prev_space_o
);

    localparam int GAP_W = $clog2(IDLE_MAX + 1);
    localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(IDLE_MAX);

    prev_kind_t         kind_q;
    logic [SPACE_W-1:0] space_q;
    logic [GAP_W-1:0]   gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= '0;
            space_q <= '0;
            gap_q   <= '0;
        end else if (start_i) begin
            kind_q.valid <= 1'b1;
            kind_q.write <= new_wr_i;
            space_q      <= new_space_i;
            gap_q        <= '0;
        end else if (quiet_i && (gap_q != GAP_LIMIT)) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assign prev_ok_o    = kind_q.valid && (gap_q != GAP_LIMIT);
    assign prev_wr_o    = kind_q.write;
    assign prev_space_o = space_q;

endmodule

// File: rtl/idlegap_calc.sv
module idlegap_calc
    import idlegap_pkg::*;
#(
    parameter int NUM_SPACES = 8,
    parameter int SPACE_W    = 3
) (
    input  logic                        prev_ok_i,
    input  logic                        prev_wr_i,
    input  logic [SPACE_W-1:0]          prev_space_i,
    input  logic                        new_wr_i,
    input  logic [SPACE_W-1:0]          new_space_i,
    input  logic [NUM_SPACES*CFG_W-1:0] cfg_i,
    output pair_class_e                 class_o,
    output idle_cnt_t                   count_o
);

    space_cfg_t cfg_arr [NUM_SPACES];

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_unpack
        assign cfg_arr[s] = cfg_i[s*CFG_W +: CFG_W];
    end

    space_cfg_t  word;
    idle_cnt_t   programmed;
    idle_cnt_t   floor_cnt;
    pair_class_e cls;

    always_comb begin
        word = '0;
        for (int s = 0; s < NUM_SPACES; s++) begin
            if (prev_space_i == SPACE_W'(s)) word = cfg_arr[s];
        end
    end

    always_comb begin
        cls        = classify(prev_ok_i, prev_wr_i, new_wr_i,
                              prev_space_i == new_space_i);
        programmed = (cls == PC_NONE) ? idle_cnt_t'(0) : word[field_lsb(cls) +: CNT_W];
        floor_cnt  = mandatory_floor(prev_ok_i, prev_wr_i, new_wr_i);
    end

    assign class_o = cls;
    assign count_o = cnt_max(programmed, floor_cnt);

endmodule

// File: rtl/idlegap_timer.sv
module idlegap_timer
    import idlegap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid_i,
    input  idle_cnt_t count_i,
    output logic      start_o,
    output logic      idle_o,
    output logic      armed_o
);

    logic      armed_q;
    idle_cnt_t remain_q;
    logic      go;

    always_comb begin
        if (!req_valid_i)  go = 1'b0;
        else if (armed_q)  go = (remain_q == '0);
        else               go = (count_i == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            remain_q <= '0;
        end else if (req_valid_i) begin
            if (armed_q) begin
                if (remain_q == '0) armed_q  <= 1'b0;
                else                remain_q <= remain_q - idle_cnt_t'(1);
            end else if (count_i != '0) begin
                armed_q  <= 1'b1;
                remain_q <= count_i - idle_cnt_t'(1);
            end
        end
    end

    assign start_o = go;
    assign idle_o  = req_valid_i && !go;
    assign armed_o = armed_q;

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
    import idlegap_pkg::*;
#(
    parameter int NUM_SPACES = 8,
    parameter int SPACE_W    = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid_i,
    input  logic                        req_write_i,
    input  logic [SPACE_W-1:0]          req_space_i,
    input  logic [NUM_SPACES*CFG_W-1:0] cfg_idle_i,
    output logic                        start_o,
    output logic                        idle_o
);

    logic               prev_ok;
    logic               prev_wr;
    logic [SPACE_W-1:0] prev_space;
    pair_class_e        pair_cls;
    idle_cnt_t          idle_cnt;
    logic               armed;
    logic               start;

    idlegap_prev_tracker #(.SPACE_W(SPACE_W)) u_prev (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .quiet_i      (!req_valid_i && !armed),
        .new_wr_i     (req_write_i),
        .new_space_i  (req_space_i),
        .prev_ok_o    (prev_ok),
        .prev_wr_o    (prev_wr),
        .prev_space_o (prev_space)
    );

    idlegap_calc #(.NUM_SPACES(NUM_SPACES), .SPACE_W(SPACE_W)) u_calc (
        .prev_ok_i    (prev_ok),
        .prev_wr_i    (prev_wr),
        .prev_space_i (prev_space),
        .new_wr_i     (req_write_i),
        .new_space_i  (req_space_i),
        .cfg_i        (cfg_idle_i),
        .class_o      (pair_cls),
        .count_o      (idle_cnt)
    );

    idlegap_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid_i),
        .count_i     (idle_cnt),
        .start_o     (start),
        .idle_o      (idle_o),
        .armed_o     (armed)
    );

    assign start_o = start;

endmodule

// File: rtl/idlegap_checker.sv
module idlegap_checker #(
    parameter int SPACE_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid_i,
    input logic               req_write_i,
    input logic [SPACE_W-1:0] req_space_i,
    input logic               start_o,
    input logic               idle_o
);

    logic [2:0] idle_run;
    logic [2:0] since_start;
    logic       last_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run    <= '0;
            since_start <= '0;
            last_rd     <= 1'b0;
        end else begin
            idle_run <= idle_o ? ((idle_run == 3'd7) ? idle_run : idle_run + 3'd1) : 3'd0;
            if (start_o) begin
                since_start <= 3'd1;
                last_rd     <= !req_write_i;
            end else if (since_start != 3'd7) begin
                since_start <= since_start + 3'd1;
            end
        end
    end

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(start_o && idle_o));

    p_start_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        start_o |-> req_valid_i);

    p_idle_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> req_valid_i);

    p_idle_bound_r9: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> (idle_run <= 3'd2));

    p_rd_rd_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (start_o && !req_write_i && last_rd) |-> (since_start >= 3'd2));

    p_rd_wr_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        (start_o && req_write_i && last_rd) |-> (since_start >= 3'd3));

    p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
        (idle_o && req_valid_i) |=> (req_valid_i && $stable(req_write_i) && $stable(req_space_i)));

endmodule

bind idle_gap_inserter idlegap_checker #(.SPACE_W(SPACE_W)) u_idlegap_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_space_i (req_space_i),
    .start_o     (start_o),
    .idle_o      (idle_o)
);

// File: tb/idle_gap_inserter_tb_top.sv
module idle_gap_inserter_tb_top;

    localparam int NS = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [SW-1:0] req_space = '0;
    logic [NS*10-1:0] cfg = '0;
    logic          start_w;
    logic          idle_w;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_valid = 0;
    int m_wr    = 0;
    int m_space = 0;
    int m_gap   = 0;

    always #10 clk = ~clk;

    idle_gap_inserter #(.NUM_SPACES(NS)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_space_i (req_space),
        .cfg_idle_i  (cfg),
        .start_o     (start_w),
        .idle_o      (idle_w)
    );

    // field order in a space word: after-write, rd->wr other, rd->wr same, rd->rd other, rd->rd same
    function automatic logic [9:0] word(input int aw, input int rwo, input int rws,
                                        input int rro, input int rrs);
        return {rrs[1:0], rro[1:0], rws[1:0], rwo[1:0], aw[1:0]};
    endfunction

    function automatic int field(input int sp, input int lsb);
        return int'(cfg[sp*10 + lsb +: 2]);
    endfunction

    function automatic int expected_idles(input int wr, input int sp);
        int n;
        if (!(m_valid != 0 && m_gap < 3)) n = wr ? 1 : 0;
        else if (m_wr != 0)              n = field(m_space, 0);
        else if (wr != 0) begin
            n = field(m_space, (sp == m_space) ? 4 : 2);
            if (n < 2) n = 2;
        end else begin
            n = field(m_space, (sp == m_space) ? 8 : 6);
            if (n < 1) n = 1;
        end
        return n;
    endfunction

    task automatic check(input string req, input int got_s, input int got_i,
                         input int exp_s, input int exp_i);
        n_cmp++;
        if (got_s != exp_s || got_i != exp_i) begin
            n_bad++;
            $display("FAIL %s: start/idle actual %0d/%0d expected %0d/%0d at %0t",
                     req, got_s, got_i, exp_s, exp_i, $time);
        end
    endtask

    task automatic access(input int wr, input int sp, input string req);
        int n;
        n = expected_idles(wr, sp);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_write = wr[0];
            req_space = sp[SW-1:0];
            #1;
            check(req, int'(start_w), int'(idle_w), (k == n) ? 1 : 0, (k == n) ? 0 : 1);
        end
        m_valid = 1;
        m_wr    = wr;
        m_space = sp;
        m_gap   = 0;
    endtask

    task automatic quiet(input int cycles, input string req);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check(req, int'(start_w), int'(idle_w), 0, 0);
            if (m_gap < 3) m_gap++;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        cfg[0*10 +: 10] = word(3, 0, 3, 2, 0);
        cfg[1*10 +: 10] = word(0, 3, 1, 0, 3);
        cfg[2*10 +: 10] = word(1, 2, 2, 3, 1);
        cfg[3*10 +: 10] = word(2, 1, 0, 1, 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset", int'(start_w), int'(idle_w), 0, 0);

        access(0, 0, "R1 first read");
        access(0, 0, "R4 rd-rd same floor 1");
        access(1, 0, "R5 rd-wr same cfg 3");
        access(1, 1, "R3 R7 wr-wr prev space0");
        access(0, 1, "R3 wr-rd cfg 0");
        access(0, 2, "R4 R6 rd-rd other cfg 0");
        access(1, 2, "R5 R6 rd-wr same cfg 2");
        access(0, 3, "R3 wr-rd space2 cfg 1");
        access(1, 0, "R5 R7 rd-wr other floor 2");
        quiet(3, "R8 quiet");
        access(1, 1, "R8 R2 write after forget");
        quiet(2, "R8 quiet short");
        access(0, 1, "R8 kept after 2");
        access(0, 1, "R4 rd-rd same cfg 3");
        access(1, 2, "R5 rd-wr other cfg 3");
        quiet(5, "R8 long quiet");
        access(0, 3, "R1 read after forget");
        access(0, 3, "R4 rd-rd same cfg 2");
        access(1, 3, "R5 rd-wr same floor 2");
        access(1, 3, "R3 wr-wr cfg 2");

        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(int'(lfsr[0]), int'(lfsr[3:2]), "R9 mixed");
            if (lfsr[7:5] < 3'd5) quiet(int'(lfsr[7:5]), "R8 mixed quiet");
        end

        quiet(1, "R10 end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule